// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing half of a UART. A 32-bit register bus with word offsets reaches a transmit byte queue and a receive byte queue, 128 entries each by default. It also reaches the line-control, flow-control and divider settings and a four-source interrupt controller. The block does not shift bits itself. A byte handshake feeds the transmit shifter, and another takes completed characters from the receive shifter together with their parity, framing and break flags. The shifters and the baud generator read the exported configuration fields.

Two interrupt sources follow the queue fill levels against programmable thresholds. Receive-full is raised while the receive queue holds at least its threshold. Transmit-empty is raised while the transmit queue holds no more than its threshold. The other two sources are sticky. The break source is set by any arriving character that carries a break flag. The idle-timeout source is set when the receive queue has held data with no new arrival for a programmable number of clocks. Each sticky source is cleared by writing one to its bit in the clear register. A masked status register shows raw sources ANDed with the enable register, and `irq` is the OR of that masked word.

The idle timeout is a three-state machine. In TO_IDLE the receive queue is empty. TO_IDLE goes to TO_COUNT on any arrival. In TO_COUNT an arrival restarts the count, and an empty queue returns the machine to TO_IDLE. When the count reaches a non-zero limit, the machine goes to TO_FIRED and sets the sticky flag. TO_FIRED returns to TO_COUNT on an arrival, or to TO_IDLE when the queue empties.

Top module: `uart_regctl`

## Requirements
- R1: After reset the interrupt enable register reads 0, the threshold register reads 0x4040, the count register reads 0, `irq` is 0 and `tx_avail` is 0.
- R2: A bus write to word offset 0x00 appends bits 7:0 to the transmit queue. Bits 15:8 of the count register (0x0C) give the transmit fill. `tx_byte` presents the oldest byte while `tx_avail` is 1, and each cycle with `tx_take` high removes it.
- R3: A write to 0x00 while the transmit queue holds 128 bytes is dropped and leaves the fill at 128. Line-status (0x08) bit 15 reads 1 only while the transmit queue is not full.
- R4: Each cycle with `rx_push` high appends a character to the receive queue, and bits 7:0 of 0x0C give the receive fill. A read of 0x04 returns the oldest byte and removes it. Line-status bits 2 (parity), 3 (framing) and 7 (break) show the flags of the oldest character. A read of 0x04 with the queue empty returns 0 and leaves the fill at 0.
- R5: An arrival while the receive queue is full is dropped and sets line-status bit 4. That bit clears after a read of 0x08.
- R6: Interrupt bit 0 is raised while the receive fill is at or above threshold bits 6:0. Interrupt bit 1 is raised while the transmit fill is at or below threshold bits 15:8. Both follow the fill levels with no clear.
- R7: Masked status (0x2C) equals the raw sources ANDed with the enable register (0x10), and `irq` is 1 exactly when masked status is non-zero. Writing all ones to the clear register (0x14) with the enable register at zero leaves `irq` at 0 and masked status at 0.
- R8: An arrival with `rx_brk` high sets interrupt bit 7, and writing 1 to clear-register bit 7 clears it.
- R9: With control-1 (0x1C) bits 14:9 at N > 0, interrupt bit 13 sets N cycles after the last arrival while receive data is held. It does not set when N is 0. Writing 1 to clear-register bit 13 clears it, and a new arrival re-arms it.
- R10: Line control (0x18) drives the exported fields: bit 1 enables parity, bit 0 selects odd parity, bits 3:2 set the data-bit code and bits 5:4 set the stop-bit code. Control-1 bit 15 drives the DMA enable and bits 6, 7 and 8 drive the flow-control outputs. The divider is {0x28 bits 4:0, 0x24 bits 15:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Combined interrupt |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Shifter consumes `tx_byte` |
| rx_byte | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of character |
| rx_ferr | input | 1 | Framing error flag of character |
| rx_brk | input | 1 | Break flag of character |
| rx_push | input | 1 | Character valid |
| cfg_parity_en | output | 1 | Parity enable |
| cfg_parity_odd | output | 1 | Odd parity select |
| cfg_data_bits | output | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_stop_bits | output | 2 | Stop-bit code |
| cfg_divisor | output | 21 | Baud divider |
| cfg_dma_en | output | 1 | DMA request enable |
| cfg_rx_flow_thr | output | 1 | Receive flow threshold flag |
| cfg_rx_flow_en | output | 1 | Receive flow control enable |
| cfg_tx_flow_en | output | 1 | Transmit flow control enable |

## Verification
Reads are combinational, so read data is sampled within the same cycle as the strobe, before the edge that performs any pop. Writes, pushes and takes show in counts, status and `irq` right after the edge that accepts them. The bench drives each access between falling edges and samples at the next falling edge. The idle flag sets on the N-th edge after the arrival edge. The bench checks that the flag is still clear one cycle before that edge and set just after it.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;
    typedef enum logic [3:0] {
        W_TXDATA = 4'd0, W_RXDATA = 4'd1, W_LINESTAT = 4'd2, W_FILL = 4'd3,
        W_INTEN = 4'd4, W_INTCLR = 4'd5, W_LINECTL = 4'd6, W_CTRL1 = 4'd7,
        W_THRESH = 4'd8, W_DIVLO = 4'd9, W_DIVHI = 4'd10, W_INTSTAT = 4'd11
    } reg_word_e;

    localparam int IB_RXFULL  = 0;
    localparam int IB_TXEMPTY = 1;
    localparam int IB_BREAK   = 7;
    localparam int IB_IDLE    = 13;
    localparam logic [15:0] INT_MASK = 16'h2083;

    localparam int LS_PERR  = 2;
    localparam int LS_FERR  = 3;
    localparam int LS_OVR   = 4;
    localparam int LS_BRK   = 7;
    localparam int LS_TXRDY = 15;

    localparam logic [15:0] CTRL1_MASK = 16'hFFC0;

    typedef enum logic [1:0] {TO_IDLE, TO_COUNT, TO_FIRED} idle_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int W = 8,
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
    import uart_regctl_pkg::*;
#(
    parameter int LIM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrive,
    input  logic             rx_empty,
    input  logic [LIM_W-1:0] limit,
    input  logic             clr,
    output logic             flag
);
    idle_state_e      state, state_nxt;
    logic [LIM_W-1:0] cnt, cnt_nxt;
    logic             fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        fire      = 1'b0;
        unique case (state)
            TO_IDLE: begin
                if (arrive) begin
                    state_nxt = TO_COUNT;
                    cnt_nxt   = '0;
                end
            end
            TO_COUNT: begin
                if (arrive) begin
                    cnt_nxt = '0;
                end else if (rx_empty) begin
                    state_nxt = TO_IDLE;
                end else if (limit != '0 &&
                             ({1'b0, cnt} + 1'b1) == {1'b0, limit}) begin
                    state_nxt = TO_FIRED;
                    fire      = 1'b1;
                end else if (limit != '0) begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            TO_FIRED: begin
                if (arrive) begin
                    state_nxt = TO_COUNT;
                    cnt_nxt   = '0;
                end else if (rx_empty) begin
                    state_nxt = TO_IDLE;
                end
            end
            default: state_nxt = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flag <= 1'b0;
        else if (fire) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    p_fire_from_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(state) == TO_COUNT));
    p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(limit) != '0));
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int IDLE_W = 6,
    parameter int DIV_W  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [5:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq,
    output logic [7:0]       tx_byte,
    output logic             tx_avail,
    input  logic             tx_take,
    input  logic [7:0]       rx_byte,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             rx_brk,
    input  logic             rx_push,
    output logic             cfg_parity_en,
    output logic             cfg_parity_odd,
    output logic [1:0]       cfg_data_bits,
    output logic [1:0]       cfg_stop_bits,
    output logic [DIV_W-1:0] cfg_divisor,
    output logic             cfg_dma_en,
    output logic             cfg_rx_flow_thr,
    output logic             cfg_rx_flow_en,
    output logic             cfg_tx_flow_en
);
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int DIVH_W = DIV_W - 16;

    logic              wr_en, rd_en;
    reg_word_e         widx;
    logic [15:0]       inten_q, ctrl1_q, div_lo_q;
    logic [DIVH_W-1:0] div_hi_q;
    logic [6:0]        rx_thr_q;
    logic [7:0]        tx_thr_q;
    logic [5:0]        linectl_q;
    logic              brk_q, ovr_q, idle_flag;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    rx_char_t          rx_in, rx_head;
    logic [15:0]       raw_int, masked_int, linestat;
    logic              unused_bits;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;
    assign widx  = reg_word_e'(bus_addr[5:2]);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

    uart_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en && widx == W_TXDATA), .din(bus_wdata[7:0]),
        .pop(tx_take), .dout(tx_byte), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty));

    assign rx_in = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_byte};

    uart_byte_fifo #(.W($bits(rx_char_t)), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_in),
        .pop(rd_en && widx == W_RXDATA), .dout(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty));

    uart_rx_idle #(.LIM_W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .arrive(rx_push), .rx_empty(rx_empty),
        .limit(ctrl1_q[9 +: IDLE_W]),
        .clr(wr_en && widx == W_INTCLR && bus_wdata[IB_IDLE]),
        .flag(idle_flag));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inten_q   <= '0;
            ctrl1_q   <= '0;
            div_lo_q  <= '0;
            div_hi_q  <= '0;
            rx_thr_q  <= 7'h40;
            tx_thr_q  <= 8'h40;
            linectl_q <= '0;
        end else if (wr_en) begin
            case (widx)
                W_INTEN:   inten_q   <= bus_wdata[15:0] & INT_MASK;
                W_CTRL1:   ctrl1_q   <= bus_wdata[15:0] & CTRL1_MASK;
                W_DIVLO:   div_lo_q  <= bus_wdata[15:0];
                W_DIVHI:   div_hi_q  <= bus_wdata[DIVH_W-1:0];
                W_LINECTL: linectl_q <= bus_wdata[5:0];
                W_THRESH: begin
                    rx_thr_q <= bus_wdata[6:0];
                    tx_thr_q <= bus_wdata[15:8];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (rx_push && rx_brk) brk_q <= 1'b1;
            else if (wr_en && widx == W_INTCLR && bus_wdata[IB_BREAK]) brk_q <= 1'b0;
            if (rx_push && rx_full) ovr_q <= 1'b1;
            else if (rd_en && widx == W_LINESTAT) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        raw_int              = '0;
        raw_int[IB_RXFULL]   = 32'(rx_cnt) >= 32'(rx_thr_q);
        raw_int[IB_TXEMPTY]  = 32'(tx_cnt) <= 32'(tx_thr_q);
        raw_int[IB_BREAK]    = brk_q;
        raw_int[IB_IDLE]     = idle_flag;
        masked_int           = raw_int & inten_q;
        linestat             = '0;
        linestat[LS_PERR]    = !rx_empty && rx_head.perr;
        linestat[LS_FERR]    = !rx_empty && rx_head.ferr;
        linestat[LS_BRK]     = !rx_empty && rx_head.brk;
        linestat[LS_OVR]     = ovr_q;
        linestat[LS_TXRDY]   = !tx_full;
    end

    assign irq = |masked_int;

    always_comb begin
        bus_rdata = '0;
        case (widx)
            W_RXDATA:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_head.data);
            W_LINESTAT: bus_rdata = 32'(linestat);
            W_FILL:     bus_rdata = (32'(tx_cnt) << 8) | 32'(rx_cnt);
            W_INTEN:    bus_rdata = 32'(inten_q);
            W_LINECTL:  bus_rdata = 32'(linectl_q);
            W_CTRL1:    bus_rdata = 32'(ctrl1_q);
            W_THRESH:   bus_rdata = (32'(tx_thr_q) << 8) | 32'(rx_thr_q);
            W_DIVLO:    bus_rdata = 32'(div_lo_q);
            W_DIVHI:    bus_rdata = 32'(div_hi_q);
            W_INTSTAT:  bus_rdata = 32'(masked_int);
            default:    bus_rdata = '0;
        endcase
    end

    assign tx_avail        = !tx_empty;
    assign cfg_parity_en   = linectl_q[1];
    assign cfg_parity_odd  = linectl_q[0];
    assign cfg_data_bits   = linectl_q[3:2];
    assign cfg_stop_bits   = linectl_q[5:4];
    assign cfg_divisor     = {div_hi_q, div_lo_q};
    assign cfg_dma_en      = ctrl1_q[15];
    assign cfg_rx_flow_thr = ctrl1_q[6];
    assign cfg_rx_flow_en  = ctrl1_q[7];
    assign cfg_tx_flow_en  = ctrl1_q[8];

    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_INTCLR && bus_wdata == 32'hFFFF_FFFF && inten_q == '0)
        |=> !irq);
    p_status_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && widx == W_INTSTAT) |-> ((bus_rdata[15:0] & ~inten_q) == '0));
    p_break_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_INTCLR && bus_wdata[IB_BREAK] && !(rx_push && rx_brk))
        |=> !brk_q);
    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovr_q);
endmodule

// File: tb/uart_regctl_tb.sv
`timescale 1ns/1ps
module uart_regctl_tb;
    localparam logic [5:0] A_TX = 6'h00, A_RX = 6'h04, A_LS = 6'h08, A_FILL = 6'h0C,
                           A_IEN = 6'h10, A_ICLR = 6'h14, A_LCR = 6'h18, A_CTL1 = 6'h1C,
                           A_THR = 6'h20, A_DIVL = 6'h24, A_DIVH = 6'h28, A_MIS = 6'h2C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0;
    logic [5:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic irq, tx_avail, tx_take = 0;
    logic [7:0] tx_byte, rx_byte = 0;
    logic rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_push = 0;
    logic cfg_parity_en, cfg_parity_odd, cfg_dma_en, cfg_rx_flow_thr, cfg_rx_flow_en, cfg_tx_flow_en;
    logic [1:0] cfg_data_bits, cfg_stop_bits;
    logic [20:0] cfg_divisor;

    int nchk = 0, nfail = 0;
    logic [7:0] txq[$];
    logic [10:0] rxq[$];
    logic brk_m;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    uart_regctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_byte(tx_byte),
        .tx_avail(tx_avail), .tx_take(tx_take), .rx_byte(rx_byte), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_push(rx_push),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_data_bits(cfg_data_bits), .cfg_stop_bits(cfg_stop_bits),
        .cfg_divisor(cfg_divisor), .cfg_dma_en(cfg_dma_en), .cfg_rx_flow_thr(cfg_rx_flow_thr),
        .cfg_rx_flow_en(cfg_rx_flow_en), .cfg_tx_flow_en(cfg_tx_flow_en));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
        rx_push = 1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
        @(negedge clk);
        rx_push = 0; rx_brk = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    task automatic tx_pull();
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
    endtask

    function automatic logic [31:0] exp_status(input int rxc, input int txc, input int rt,
            input int tt, input logic [15:0] en, input logic bk, input logic idl);
        logic [31:0] r = 0;
        r[0] = rxc >= rt;
        r[1] = txc <= tt;
        r[7] = bk;
        r[13] = idl;
        return r & {16'h0, en};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_IEN, rv);  chk("R1 enable", rv, 0);
        bus_read(A_THR, rv);  chk("R1 thresholds", rv, 32'h4040);
        bus_read(A_FILL, rv); chk("R1 fill", rv, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 tx_avail", {31'd0, tx_avail}, 0);

        // R10 configuration export
        bus_write(A_LCR, 32'h3B);
        bus_write(A_CTL1, 32'h81C0);
        bus_write(A_DIVL, 32'hBEEF);
        bus_write(A_DIVH, 32'h1F5);
        chk("R10 parity en", {31'd0, cfg_parity_en}, 1);
        chk("R10 parity odd", {31'd0, cfg_parity_odd}, 1);
        chk("R10 data bits", {30'd0, cfg_data_bits}, 2);
        chk("R10 stop bits", {30'd0, cfg_stop_bits}, 3);
        chk("R10 flow", {28'd0, cfg_dma_en, cfg_tx_flow_en, cfg_rx_flow_en, cfg_rx_flow_thr}, 4'hF);
        chk("R10 divisor", {11'd0, cfg_divisor}, {11'd0, 5'h15, 16'hBEEF});
        bus_read(A_DIVH, rv); chk("R10 divhi readback", rv, 32'h15);
        bus_write(A_CTL1, 0);

        // R2 transmit path
        bus_write(A_TX, 32'h11);
        bus_write(A_TX, 32'h22);
        bus_read(A_FILL, rv); chk("R2 tx fill", rv, 32'h0200);
        chk("R2 avail", {31'd0, tx_avail}, 1);
        chk("R2 head", {24'd0, tx_byte}, 32'h11);
        tx_pull();
        chk("R2 second", {24'd0, tx_byte}, 32'h22);
        tx_pull();
        chk("R2 drained", {31'd0, tx_avail}, 0);

        // R3 transmit full drop
        for (int i = 0; i < 129; i++) bus_write(A_TX, i);
        bus_read(A_FILL, rv); chk("R3 full fill", rv, 32'h8000);
        bus_read(A_LS, rv);   chk("R3 txready low", rv & 32'h8000, 0);
        for (int i = 0; i < 128; i++) begin
            if (i == 0 || i == 127) chk("R3 order", {24'd0, tx_byte}, i);
            tx_pull();
        end
        chk("R3 dropped byte absent", {31'd0, tx_avail}, 0);
        bus_read(A_LS, rv); chk("R3 txready high", rv, 32'h8000);

        // R4 receive path with flags
        rx_send(8'h3C, 1, 0, 0);
        rx_send(8'h5A, 0, 1, 0);
        bus_read(A_FILL, rv); chk("R4 rx fill", rv, 2);
        bus_read(A_LS, rv);   chk("R4 parity flag", rv, 32'h8004);
        bus_read(A_RX, rv);   chk("R4 data1", rv, 32'h3C);
        bus_read(A_LS, rv);   chk("R4 framing flag", rv, 32'h8008);
        bus_read(A_RX, rv);   chk("R4 data2", rv, 32'h5A);
        bus_read(A_RX, rv);   chk("R4 empty read", rv, 0);
        bus_read(A_FILL, rv); chk("R4 empty fill", rv, 0);

        // R5 receive overrun
        for (int i = 0; i < 129; i++) rx_send(8'(i + 1), 0, 0, 0);
        bus_read(A_FILL, rv); chk("R5 fill", rv, 128);
        bus_read(A_LS, rv);   chk("R5 overrun set", rv, 32'h8010);
        bus_read(A_LS, rv);   chk("R5 overrun cleared", rv, 32'h8000);
        for (int i = 0; i < 128; i++) begin
            bus_read(A_RX, rv);
            if (i == 0 || i == 127) chk("R5 order", rv, i + 1);
        end

        // R6 level interrupts
        bus_write(A_THR, 32'h0203);
        bus_write(A_IEN, 32'h1);
        rx_send(1, 0, 0, 0); rx_send(2, 0, 0, 0);
        chk("R6 rx below threshold", {31'd0, irq}, 0);
        rx_send(3, 0, 0, 0);
        chk("R6 rx at threshold", {31'd0, irq}, 1);
        bus_read(A_RX, rv);
        chk("R6 rx level falls", {31'd0, irq}, 0);
        bus_write(A_IEN, 32'h2);
        chk("R6 tx empty", {31'd0, irq}, 1);
        for (int i = 0; i < 3; i++) bus_write(A_TX, i);
        chk("R6 tx above threshold", {31'd0, irq}, 0);
        tx_pull();
        chk("R6 tx at threshold", {31'd0, irq}, 1);
        tx_pull(); tx_pull();
        bus_read(A_RX, rv); bus_read(A_RX, rv);

        // R7 clear-all with nothing enabled
        bus_write(A_IEN, 0);
        bus_write(A_ICLR, 32'hFFFF_FFFF);
        chk("R7 irq after clear", {31'd0, irq}, 0);
        bus_read(A_MIS, rv); chk("R7 status zero", rv, 0);

        // R8 break sticky
        bus_write(A_IEN, 32'h80);
        rx_send(8'h00, 0, 0, 1);
        bus_read(A_MIS, rv); chk("R8 break set", rv, 32'h80);
        bus_read(A_LS, rv);  chk("R8 head break", rv, 32'h8080);
        bus_write(A_ICLR, 32'h80);
        chk("R8 break cleared", {31'd0, irq}, 0);
        bus_read(A_RX, rv);

        // R9 idle timeout, limit 5
        bus_write(A_CTL1, 32'h0A00);
        bus_write(A_ICLR, 32'h2000);
        bus_write(A_IEN, 32'h2000);
        rx_send(8'h77, 0, 0, 0);
        repeat (4) @(negedge clk);
        bus_read(A_MIS, rv); chk("R9 not yet", rv, 0);
        bus_read(A_MIS, rv); chk("R9 fired", rv, 32'h2000);
        chk("R9 irq", {31'd0, irq}, 1);
        bus_write(A_ICLR, 32'h2000);
        chk("R9 cleared", {31'd0, irq}, 0);
        rx_send(8'h78, 0, 0, 0);
        repeat (6) @(negedge clk);
        chk("R9 rearmed", {31'd0, irq}, 1);
        bus_write(A_CTL1, 0);
        bus_write(A_ICLR, 32'h2000);
        rx_send(8'h79, 0, 0, 0);
        repeat (40) @(negedge clk);
        chk("R9 zero limit disabled", {31'd0, irq}, 0);
        for (int i = 0; i < 3; i++) bus_read(A_RX, rv);

        // Random mix: R2 R4 R6 R7 against bench model
        bus_write(A_THR, 32'h0304);
        bus_write(A_IEN, 32'h83);
        bus_write(A_ICLR, 32'hFFFF_FFFF);
        brk_m = 0;
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: begin
                    logic [7:0] b; int f;
                    b = 8'($urandom); f = int'($urandom % 8);
                    if (rxq.size() < 128) rxq.push_back({f == 7, f[1], f[0], b});
                    if (f == 7) brk_m = 1;
                    rx_send(b, f[0], f[1], f == 7);
                end
                1: begin
                    logic [31:0] e;
                    e = (rxq.size() == 0) ? 0 : {24'd0, rxq[0][7:0]};
                    bus_read(A_RX, rv);
                    chk("R4 random read", rv, e);
                    if (rxq.size() != 0) void'(rxq.pop_front());
                end
                2: begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    if (txq.size() < 128) txq.push_back(b);
                    bus_write(A_TX, {24'd0, b});
                end
                3: begin
                    if (txq.size() != 0) begin
                        chk("R2 random head", {24'd0, tx_byte}, {24'd0, txq[0]});
                        void'(txq.pop_front());
                    end
                    tx_pull();
                end
                default: begin
                    bus_write(A_ICLR, 32'h80);
                    brk_m = 0;
                end
            endcase
            bus_read(A_FILL, rv);
            chk("R2 R4 random fill", rv, (txq.size() << 8) | rxq.size());
            bus_read(A_MIS, rv);
            chk("R6 random status", rv, exp_status(rxq.size(), txq.size(), 4, 3, 16'h83, brk_m, 0));
            chk("R7 random irq", {31'd0, irq}, {31'd0, rv != 0});
        end

        summary();
        $finish;
    end
endmodule